// File: doc/BRIEF.md
# Stop-Mode Entry and Wakeup Controller

This block puts a small processor core into a deep-sleep stop state and brings it back out. A one-cycle request from software starts the sequence. The block then does four things: it removes the clock enable, clears the clock prescaler and the timing divider, asserts a retention hold for registers, memory and port latches, and holds the core halted. The release conditions are captured at the moment of the request. These are the release style, the key-wakeup enable mask and a low-power flash option. The block also records the address where execution resumes.

Two release styles are available. The level style wakes the core while a dedicated stop pin is high, or while any enabled key-wakeup input is high. In this style, a stop pin that is already high when the request arrives sends the block straight into warm-up without stopping. The edge style reacts only to a rising edge on the stop pin, and it ignores the key inputs. Every wakeup runs a warm-up count. When the flash option was set, a supply-stabilization count follows. The block then gives the core a single resume pulse.

Software must disable interrupts before the request and clear stale interrupt latches after resuming. The block does not touch the interrupt logic.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After reset, `status` reads 0 (idle), `clk_en`=1, `core_halt`=0, `prescaler_clr`=0, `retain_hold`=0 and `resume_pulse`=0. The `status` codes are 0 idle, 1 stopped, 2 warm-up, 3 stabilize, 4 run.
- R2: When `stop_req` is high in idle and no abort applies, the next cycle shows `status`=1 with `clk_en`=0, `core_halt`=1, `prescaler_clr`=1 and `retain_hold`=1.
- R3: In level style (`rel_level`=1 at the request), the stopped state leaves for warm-up while the synchronized `stop_pin` is high, or while any `key_in[i]` is high whose `key_en[i]` bit was 1 at the request. A high key input whose enable bit is 0 has no effect.
- R4: In level style, if the synchronized `stop_pin` is high in the cycle of the request, the next cycle shows `status`=2 and the stopped state is skipped.
- R5: In edge style (`rel_level`=0), only a rising edge of the stop pin releases the block, seen after a two-flop synchronizer (warm-up shows 3 cycles after the pin rises). A pin that is already high, and all `key_in` activity, leave the block stopped.
- R6: Warm-up lasts exactly `WARM_CYCLES` cycles. During it `clk_en`=0, `core_halt`=1 and `prescaler_clr`=0.
- R7: If `lp_flash` was 1 at the request, a stabilize phase of exactly `STAB_CYCLES` cycles follows warm-up. Otherwise the stabilize phase is absent.
- R8: After the waits, `status`=4 for one cycle with `resume_pulse`=1, `clk_en`=1 and `core_halt`=0, and the next cycle is idle.
- R9: `resume_pc` equals `stop_pc` at the request plus 2, modulo 2^`PCW`. It keeps that value until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | One-cycle stop request from the control-register write |
| rel_level | input | 1 | Release style: 1 level, 0 edge |
| key_en | input | NKEY | Per-input key-wakeup enable mask |
| lp_flash | input | 1 | Adds the stabilize wait after warm-up |
| stop_pc | input | PCW | Address of the instruction issuing the request |
| stop_pin | input | 1 | Dedicated asynchronous stop-release pin |
| key_in | input | NKEY | Asynchronous key-wakeup inputs, active high |
| clk_en | output | 1 | Core clock enable |
| core_halt | output | 1 | Holds the core halted |
| prescaler_clr | output | 1 | Clears prescaler and timing divider |
| retain_hold | output | 1 | Hold for registers, memory and port latches |
| resume_pulse | output | 1 | One-cycle resume strobe |
| resume_pc | output | PCW | Address where execution resumes |
| status | output | 3 | Current phase code |

## Verification
The checker watches every cycle for several properties. It confirms that each request lands in the stopped state or, on a level-style abort, in warm-up, with the gating that belongs there. It confirms that warm-up only moves forward, that stabilize happens only when the flash option was latched, that the resume pulse lasts one cycle and returns to idle, and that the resume address is the request address plus 2.

The exact lengths of the warm-up and stabilize phases, and the delay from the pin to release, can only be shown by the bench scenarios. The same holds for the release-style behaviours: that disabled keys and edge-style keys are ignored, and that a pin already high fails to release in edge style. The scoreboard measures each phase and compares it against the expected length.

// File: rtl/swc_pkg.sv
package swc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_STOPPED = 3'd1,
        ST_WARMUP  = 3'd2,
        ST_STAB    = 3'd3,
        ST_RUN     = 3'd4
    } swc_state_e;
endpackage

// File: rtl/swc_sync_detect.sv
module swc_sync_detect #(
    parameter int NKEY = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stop_pin,
    input  logic [NKEY-1:0] key_in,
    output logic            pin_lvl,
    output logic            pin_rise,
    output logic [NKEY-1:0] key_lvl
);
    typedef struct packed {
        logic            pin_s1;
        logic            pin_s2;
        logic            pin_s3;
        logic [NKEY-1:0] key_s1;
        logic [NKEY-1:0] key_s2;
    } sync_regs_t;

    sync_regs_t r_q, r_d;

    always_comb begin
        r_d        = r_q;
        r_d.pin_s1 = stop_pin;
        r_d.pin_s2 = r_q.pin_s1;
        r_d.pin_s3 = r_q.pin_s2;
        r_d.key_s1 = key_in;
        r_d.key_s2 = r_q.key_s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // Level and edge views of the synchronized pin
    assign pin_lvl  = r_q.pin_s2;
    assign pin_rise = r_q.pin_s2 & ~r_q.pin_s3;
    assign key_lvl  = r_q.key_s2;
endmodule

// File: rtl/swc_wait_timer.sv
module swc_wait_timer #(
    parameter int WARM_CYCLES = 16384,
    parameter int STAB_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic count_en,
    input  logic in_stab,
    output logic done
);
    localparam int MAXC = (WARM_CYCLES > STAB_CYCLES) ? WARM_CYCLES : STAB_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] WARM_LAST = CW'(WARM_CYCLES - 1);
    localparam logic [CW-1:0] STAB_LAST = CW'(STAB_CYCLES - 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)           cnt_d = '0;
        else if (count_en) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = count_en && (cnt_q == (in_stab ? STAB_LAST : WARM_LAST));
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
    import swc_pkg::*;
#(
    parameter int NKEY        = 5,
    parameter int PCW         = 16,
    parameter int WARM_CYCLES = 16384,
    parameter int STAB_CYCLES = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stop_req,
    input  logic            rel_level,
    input  logic [NKEY-1:0] key_en,
    input  logic            lp_flash,
    input  logic [PCW-1:0]  stop_pc,
    input  logic            stop_pin,
    input  logic [NKEY-1:0] key_in,
    output logic            clk_en,
    output logic            core_halt,
    output logic            prescaler_clr,
    output logic            retain_hold,
    output logic            resume_pulse,
    output logic [PCW-1:0]  resume_pc,
    output logic [2:0]      status
);
    localparam logic [PCW-1:0] PC_STEP = PCW'(2);

    typedef struct packed {
        swc_state_e      state;
        logic            mode_lvl;
        logic [NKEY-1:0] ken;
        logic            lp;
        logic [PCW-1:0]  rpc;
    } ctrl_regs_t;

    ctrl_regs_t r_q, r_d;

    logic            pin_lvl_w;
    logic            pin_rise_w;
    logic [NKEY-1:0] key_lvl_w;
    logic            timer_done;
    logic            timer_clr;
    logic            timer_run;
    logic            lvl_wake;
    logic            lp_latched;

    swc_sync_detect #(.NKEY(NKEY)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .stop_pin (stop_pin),
        .key_in   (key_in),
        .pin_lvl  (pin_lvl_w),
        .pin_rise (pin_rise_w),
        .key_lvl  (key_lvl_w)
    );

    assign lvl_wake = pin_lvl_w | (|(key_lvl_w & r_q.ken));

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (stop_req) begin
                    r_d.mode_lvl = rel_level;
                    r_d.ken      = key_en;
                    r_d.lp       = lp_flash;
                    r_d.rpc      = stop_pc + PC_STEP;
                    // Level style with the pin already high skips the stop
                    r_d.state    = (rel_level && pin_lvl_w) ? ST_WARMUP : ST_STOPPED;
                end
            end
            ST_STOPPED: begin
                if (r_q.mode_lvl ? lvl_wake : pin_rise_w) r_d.state = ST_WARMUP;
            end
            ST_WARMUP: begin
                if (timer_done) r_d.state = r_q.lp ? ST_STAB : ST_RUN;
            end
            ST_STAB: begin
                if (timer_done) r_d.state = ST_RUN;
            end
            ST_RUN:  r_d.state = ST_IDLE;
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign timer_clr = (r_d.state != r_q.state);
    assign timer_run = (r_q.state == ST_WARMUP) || (r_q.state == ST_STAB);

    swc_wait_timer #(
        .WARM_CYCLES (WARM_CYCLES),
        .STAB_CYCLES (STAB_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (timer_clr),
        .count_en (timer_run),
        .in_stab  (r_q.state == ST_STAB),
        .done     (timer_done)
    );

    assign clk_en        = (r_q.state == ST_IDLE) || (r_q.state == ST_RUN);
    assign core_halt     = !clk_en;
    assign retain_hold   = !clk_en;
    assign prescaler_clr = (r_q.state == ST_STOPPED);
    assign resume_pulse  = (r_q.state == ST_RUN);
    assign resume_pc     = r_q.rpc;
    assign status        = r_q.state;
    assign lp_latched    = r_q.lp;
endmodule

// File: rtl/swc_checker.sv
module swc_checker #(
    parameter int PCW = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           stop_req,
    input logic           rel_level,
    input logic [PCW-1:0] stop_pc,
    input logic           pin_lvl,
    input logic           clk_en,
    input logic           core_halt,
    input logic           prescaler_clr,
    input logic           retain_hold,
    input logic           resume_pulse,
    input logic [PCW-1:0] resume_pc,
    input logic [2:0]     status,
    input logic           lp_q
);
    a_r2_enter_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'd0 && stop_req && !(rel_level && pin_lvl))
        |=> (status == 3'd1 && !clk_en && core_halt && prescaler_clr && retain_hold));

    a_r4_abort_to_warm: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'd0 && stop_req && rel_level && pin_lvl) |=> (status == 3'd2));

    a_r6_warm_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'd2) |=> (status == 3'd2 || status == 3'd3 || status == 3'd4));

    a_r7_stab_needs_lp: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'd3) |-> lp_q);

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pulse |=> (!resume_pulse && status == 3'd0 && clk_en));

    a_r9_resume_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'd0 && stop_req) |=> (resume_pc == $past(stop_pc) + PCW'(2)));
endmodule

bind sleep_wake_ctrl swc_checker #(.PCW(PCW)) u_swc_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .stop_req      (stop_req),
    .rel_level     (rel_level),
    .stop_pc       (stop_pc),
    .pin_lvl       (pin_lvl_w),
    .clk_en        (clk_en),
    .core_halt     (core_halt),
    .prescaler_clr (prescaler_clr),
    .retain_hold   (retain_hold),
    .resume_pulse  (resume_pulse),
    .resume_pc     (resume_pc),
    .status        (status),
    .lp_q          (lp_latched)
);

// File: tb/sleep_wake_ctrl_test.sv
module sleep_wake_ctrl_test;
    localparam int NKEY = 5;
    localparam int PCW  = 16;
    localparam int WC   = 12;
    localparam int SC   = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            stop_req = 1'b0;
    logic            rel_level = 1'b0;
    logic [NKEY-1:0] key_en = '0;
    logic            lp_flash = 1'b0;
    logic [PCW-1:0]  stop_pc = '0;
    logic            stop_pin = 1'b0;
    logic [NKEY-1:0] key_in = '0;
    logic            clk_en, core_halt, prescaler_clr, retain_hold, resume_pulse;
    logic [PCW-1:0]  resume_pc;
    logic [2:0]      status;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [PCW-1:0] pc;
        int             stab;
    } exp_item_t;
    exp_item_t exp_q[$];

    always #10ns clk = ~clk;

    sleep_wake_ctrl #(
        .NKEY(NKEY), .PCW(PCW), .WARM_CYCLES(WC), .STAB_CYCLES(SC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .rel_level(rel_level),
        .key_en(key_en), .lp_flash(lp_flash), .stop_pc(stop_pc),
        .stop_pin(stop_pin), .key_in(key_in), .clk_en(clk_en),
        .core_halt(core_halt), .prescaler_clr(prescaler_clr),
        .retain_hold(retain_hold), .resume_pulse(resume_pulse),
        .resume_pc(resume_pc), .status(status)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: pushes the expected resume item, then pulses the request
    task automatic enter_stop(input logic [PCW-1:0] pc, input logic lvl,
                              input logic [NKEY-1:0] ken, input logic lp);
        exp_q.push_back('{pc: pc + PCW'(2), stab: lp ? SC : 0});
        stop_pc   = pc;
        rel_level = lvl;
        key_en    = ken;
        lp_flash  = lp;
        stop_req  = 1'b1;
        tick(1);
        stop_req  = 1'b0;
    endtask

    task automatic wait_idle(input int max);
        for (int i = 0; i < max; i++) begin
            if (status == 3'd0) break;
            tick(1);
        end
        chk("R8 return to idle", {29'd0, status}, 32'd0);
    endtask

    // Monitor: measures phase lengths and compares each resume with the queue
    int  warm_cnt = 0;
    int  stab_cnt = 0;
    bit  after_pulse = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (after_pulse) begin
                chk("R8 idle after pulse", {29'd0, status}, 32'd0);
                chk("R8 pulse one cycle", {31'd0, resume_pulse}, 32'd0);
                after_pulse = 1'b0;
            end
            if (status == 3'd2) warm_cnt++;
            if (status == 3'd3) stab_cnt++;
            if (resume_pulse) begin
                chk("R8 clk_en at pulse", {31'd0, clk_en}, 32'd1);
                chk("R8 core_halt at pulse", {31'd0, core_halt}, 32'd0);
                if (exp_q.size() == 0) begin
                    chk("R8 unexpected resume", 32'd1, 32'd0);
                end else begin
                    exp_item_t e;
                    e = exp_q.pop_front();
                    chk("R9 resume_pc", {16'd0, resume_pc}, {16'd0, e.pc});
                    chk("R6 warm-up length", warm_cnt, WC);
                    chk("R7 stabilize length", stab_cnt, e.stab);
                end
                warm_cnt = 0;
                stab_cnt = 0;
                after_pulse = 1'b1;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 status", {29'd0, status}, 32'd0);
        chk("R1 clk_en", {31'd0, clk_en}, 32'd1);
        chk("R1 gating", {28'd0, core_halt, prescaler_clr, retain_hold, resume_pulse}, 32'd0);

        // Edge style, pin low, all keys enabled
        enter_stop(16'h1000, 1'b0, 5'h1F, 1'b0);
        chk("R2 stopped", {29'd0, status}, 32'd1);
        chk("R2 gating", {28'd0, clk_en, core_halt, prescaler_clr, retain_hold}, 32'b0111);
        key_in = 5'h1F;
        tick(10);
        chk("R5 keys ignored in edge style", {29'd0, status}, 32'd1);
        key_in = '0;
        stop_pin = 1'b1;
        tick(3);
        chk("R5 rising edge releases", {29'd0, status}, 32'd2);
        chk("R6 warm-up gating", {29'd0, clk_en, core_halt, prescaler_clr}, 32'b010);
        wait_idle(100);
        stop_pin = 1'b0;
        tick(4);

        // Edge style, pin already high at entry, flash option set, address wraps
        stop_pin = 1'b1;
        tick(4);
        enter_stop(16'hFFFF, 1'b0, 5'h00, 1'b1);
        chk("R5 high pin still stops in edge style", {29'd0, status}, 32'd1);
        tick(10);
        chk("R5 steady high pin does not release", {29'd0, status}, 32'd1);
        stop_pin = 1'b0;
        tick(5);
        chk("R5 falling pin does not release", {29'd0, status}, 32'd1);
        stop_pin = 1'b1;
        tick(3);
        chk("R5 edge releases", {29'd0, status}, 32'd2);
        tick(WC);
        chk("R7 stabilize phase", {29'd0, status}, 32'd3);
        wait_idle(100);

        // Level style with pin already high: abort into warm-up
        enter_stop(16'h0200, 1'b1, 5'h00, 1'b0);
        chk("R4 abort straight to warm-up", {29'd0, status}, 32'd2);
        stop_pin = 1'b0;
        wait_idle(100);
        tick(4);

        // Level style, one key enabled, others active but masked
        key_in = 5'b01011;
        tick(4);
        enter_stop(16'h3456, 1'b1, 5'b00100, 1'b0);
        chk("R2 level stop", {29'd0, status}, 32'd1);
        tick(10);
        chk("R3 disabled keys ignored", {29'd0, status}, 32'd1);
        key_in[2] = 1'b1;
        tick(3);
        chk("R3 enabled key releases", {29'd0, status}, 32'd2);
        key_in = '0;
        wait_idle(100);
        tick(5);
        chk("R9 resume_pc held", {16'd0, resume_pc}, 32'h3458);

        // Level style released by the pin
        enter_stop(16'h0042, 1'b1, 5'h00, 1'b0);
        chk("R2 stop again", {29'd0, status}, 32'd1);
        stop_pin = 1'b1;
        tick(3);
        chk("R3 pin level releases", {29'd0, status}, 32'd2);
        wait_idle(100);
        stop_pin = 1'b0;
        tick(3);

        chk("R8 all resumes seen", exp_q.size(), 32'd0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule